// File: doc/BRIEF.md
# Angle Hold Latch with Split Byte Bus

This block sits between a continuously running angle tracking counter and a host read bus. A 16-bit holding register follows the counter. It copies the counter on the leading edge of the counter's update strobe. The host can pull an active-low hold input to freeze this register for a consistent read. The counter keeps tracking while the register is frozen. When the hold is released, the register picks up the current count at once, without waiting for a new strobe.

The held angle leaves the block as two 8-bit groups. The upper group carries the most significant byte and the lower group carries the least significant byte. Each group has its own active-low enable. The high-impedance state of each group is modelled by an output-enable flag next to its data. The flag turns on a set number of clocks after the enable is asserted, and turns off a set number of clocks after the enable is removed. Both delays are parameters, sized to meet the drive-on and release windows at the system clock.

Top module: `angle_hold_bus`

## Requirements
- R1: During and after a synchronous reset (rst_n low), the held angle is 0, both group output-enable flags are low and both data groups read 0.
- R2: With hold_n high, a clock edge at which upd_strobe is sampled 1 after being sampled 0 on the previous edge copies count_i into the held angle at that edge. A strobe that stays high does not copy again.
- R3: From the first edge at which hold_n is sampled 0, the held angle does not change, whatever count_i does.
- R4: Leading edges of upd_strobe that occur while hold_n is sampled 0 have no effect on the held angle.
- R5: At the first edge at which hold_n is sampled 1 after being sampled 0, the held angle takes the count_i value present at that edge, with no strobe needed.
- R6: The upper group carries held-angle bits 15..8, with bit 15 as the most significant. The lower group carries bits 7..0.
- R7: A group's output-enable flag rises at the ON_DLY-th consecutive edge at which its enable is sampled low (default 3). A shorter low pulse leaves the flag low.
- R8: A group's output-enable flag falls at the OFF_DLY-th consecutive edge at which its enable is sampled high (default 2). A shorter high pulse leaves the flag high.
- R9: While a group's flag is low its data reads 0. While the flag is high its data shows the current held-angle byte.
- R10: The two groups operate independently. Enabling or disabling one group does not change the other group's flag or data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| count_i | input | 16 | Live value of the tracking counter |
| upd_strobe | input | 1 | Counter busy strobe; its leading edge requests a copy |
| hold_n | input | 1 | Active-low freeze of the held angle |
| hi_en_n | input | 1 | Active-low enable of the upper byte group |
| lo_en_n | input | 1 | Active-low enable of the lower byte group |
| hi_data | output | 8 | Upper byte of the held angle (0 when not driven) |
| hi_oe | output | 1 | Upper group is driving (low models high impedance) |
| lo_data | output | 8 | Lower byte of the held angle (0 when not driven) |
| lo_oe | output | 1 | Lower group is driving (low models high impedance) |

## Verification
A wrong held angle becomes visible on the data groups in the same clock it goes wrong, but only while a group is enabled. For this reason the bench keeps both groups enabled across the hold and release sequences. A stale or missed edge-detector state shows up one clock later as a copy that should not happen or a copy that is missing. A drive counter that is off by one moves the enable flag one clock early or late. The per-clock comparison with the reference model catches that on the first affected edge.

// File: rtl/angle_hold_pkg.sv
// Package: shared types and defaults for the angle hold latch.
// Assumes the angle width is an exact multiple of the byte width.
package angle_hold_pkg;
    localparam int ANGLE_W_DEF = 16;
    localparam int BYTE_W_DEF  = 8;

    // Drive state of one byte group.
    typedef enum logic {
        DRV_OFF = 1'b0,
        DRV_ON  = 1'b1
    } drv_state_t;
endpackage

// File: rtl/rise_detect.sv
// Module: registered rising-edge detector.
// The previous sample resets to 1, so a signal that is already high when
// reset ends is not seen as a rising edge.
module rise_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o
);
    logic prev_q;

    // Hold the level seen at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sig_i;
    end

    // A rising edge is a high now after a low at the previous edge.
    assign rise_o = sig_i & ~prev_q;

    // R2: a rising edge cannot be reported on two edges in a row.
    a_r2_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/angle_latch.sv
// Module: holding register for the tracked angle.
// It copies the counter on a strobe leading edge while hold_n is high,
// freezes while hold_n is low, and recaptures on hold release.
// Assumes upd_rise and rel_rise are single-cycle edge flags.
module angle_latch #(
    parameter int ANGLE_W = angle_hold_pkg::ANGLE_W_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ANGLE_W-1:0] count_i,
    input  logic               hold_n,
    input  logic               upd_rise,
    input  logic               rel_rise,
    output logic [ANGLE_W-1:0] held_o
);
    logic capture;

    // Copy on release or on a strobe edge, and only while not frozen.
    assign capture = hold_n & (rel_rise | upd_rise);

    // Holding register update.
    always_ff @(posedge clk) begin
        if (!rst_n)       held_o <= '0;
        else if (capture) held_o <= count_i;
    end

    // R3/R4: while frozen the held angle never moves.
    a_r3_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_n |=> $stable(held_o));
    // R5: release recaptures the live count.
    a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_n && rel_rise) |=> held_o == $past(count_i));
    // R2: strobe edge copies the count.
    a_r2_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_n && upd_rise) |=> held_o == $past(count_i));
    // R2: with no edge the value holds.
    a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_rise && !rel_rise) |=> $stable(held_o));
endmodule

// File: rtl/byte_drive.sv
// Module: one byte group of the output bus with modelled drive windows.
// The drive flag turns on after ON_DLY consecutive low samples of en_n and
// off after OFF_DLY consecutive high samples. Data reads 0 while off.
// Assumes ON_DLY >= 1 and OFF_DLY >= 1.
module byte_drive #(
    parameter int BYTE_W  = angle_hold_pkg::BYTE_W_DEF,
    parameter int ON_DLY  = 3,
    parameter int OFF_DLY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_n,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              oe_o,
    output logic [BYTE_W-1:0] data_o
);
    import angle_hold_pkg::*;

    localparam int MAXD = (ON_DLY > OFF_DLY) ? ON_DLY : OFF_DLY;
    localparam int CW   = $clog2(MAXD + 1);
    localparam logic [CW-1:0] ON_LAST  = CW'(ON_DLY - 1);
    localparam logic [CW-1:0] OFF_LAST = CW'(OFF_DLY - 1);

    drv_state_t    state_q;
    logic [CW-1:0] run_q;
    logic          want_on;
    logic          differs;
    logic          run_done;

    assign want_on  = ~en_n;
    assign differs  = (want_on != (state_q == DRV_ON));
    assign run_done = (state_q == DRV_ON) ? (run_q == OFF_LAST) : (run_q == ON_LAST);

    // Count consecutive samples that ask for the other state, then switch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DRV_OFF;
            run_q   <= '0;
        end else if (!differs) begin
            run_q   <= '0;
        end else if (run_done) begin
            state_q <= (state_q == DRV_ON) ? DRV_OFF : DRV_ON;
            run_q   <= '0;
        end else begin
            run_q   <= run_q + 1'b1;
        end
    end

    assign oe_o   = (state_q == DRV_ON);
    assign data_o = oe_o ? byte_i : '0;

    // R7: the flag only turns on after the enable was sampled low.
    a_r7_on_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_o) |-> $past(!en_n));
    // R8: the flag only turns off after the enable was sampled high.
    a_r8_off_needs_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe_o) |-> $past(en_n));
    // R7/R8: the run counter stays inside its window.
    a_r7_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run_q < CW'(MAXD));
endmodule

// File: rtl/angle_hold_bus.sv
// Module (top): angle hold latch with a split byte bus.
// It detects the strobe leading edge and the hold release, keeps the held
// angle, and drives it as an upper and a lower byte group with separate
// enables. Assumes ANGLE_W == 2 * BYTE_W.
module angle_hold_bus #(
    parameter int ANGLE_W = angle_hold_pkg::ANGLE_W_DEF,
    parameter int BYTE_W  = angle_hold_pkg::BYTE_W_DEF,
    parameter int ON_DLY  = 3,
    parameter int OFF_DLY = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ANGLE_W-1:0] count_i,
    input  logic               upd_strobe,
    input  logic               hold_n,
    input  logic               hi_en_n,
    input  logic               lo_en_n,
    output logic [BYTE_W-1:0]  hi_data,
    output logic               hi_oe,
    output logic [BYTE_W-1:0]  lo_data,
    output logic               lo_oe
);
    localparam int NGRP = ANGLE_W / BYTE_W;

    logic                         upd_rise;
    logic                         rel_rise;
    logic [ANGLE_W-1:0]           held;
    logic [NGRP-1:0]              en_n_v;
    logic [NGRP-1:0]              oe_v;
    logic [NGRP-1:0][BYTE_W-1:0]  data_v;

    rise_detect u_strobe_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig_i (upd_strobe),
        .rise_o(upd_rise)
    );

    rise_detect u_release_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig_i (hold_n),
        .rise_o(rel_rise)
    );

    angle_latch #(.ANGLE_W(ANGLE_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .count_i (count_i),
        .hold_n  (hold_n),
        .upd_rise(upd_rise),
        .rel_rise(rel_rise),
        .held_o  (held)
    );

    // Group 1 is the upper byte, group 0 the lower byte.
    assign en_n_v = {hi_en_n, lo_en_n};

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        byte_drive #(
            .BYTE_W (BYTE_W),
            .ON_DLY (ON_DLY),
            .OFF_DLY(OFF_DLY)
        ) u_drive (
            .clk   (clk),
            .rst_n (rst_n),
            .en_n  (en_n_v[g]),
            .byte_i(held[g*BYTE_W +: BYTE_W]),
            .oe_o  (oe_v[g]),
            .data_o(data_v[g])
        );
    end

    assign hi_data = data_v[NGRP-1];
    assign hi_oe   = oe_v[NGRP-1];
    assign lo_data = data_v[0];
    assign lo_oe   = oe_v[0];

    // R9: an undriven group always reads zero.
    a_r9_hi_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_oe |-> hi_data == '0);
    a_r9_lo_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !lo_oe |-> lo_data == '0);
    // R10: the lower flag cannot change on an edge where its own enable
    // agreed with it before the edge.
    a_r10_lo_indep: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_en_n == !lo_oe) |=> $stable(lo_oe));
endmodule

// File: tb/angle_hold_bus_tb.sv
module angle_hold_bus_tb;
    localparam int EN_D  = 3;
    localparam int REL_D = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] count_i = '0;
    logic        upd_strobe = 1'b0;
    logic        hold_n = 1'b1;
    logic        hi_en_n = 1'b1;
    logic        lo_en_n = 1'b1;
    logic [7:0]  hi_data, lo_data;
    logic        hi_oe, lo_oe;

    int    errors = 0;
    int    checks = 0;
    string phase = "R1";
    bit    done = 1'b0;

    // Reference model state.
    logic [15:0] m_latch;
    bit          m_hold_q, m_busy_q;
    bit          m_oe [2];
    int          m_run [2];

    angle_hold_bus #(.ON_DLY(EN_D), .OFF_DLY(REL_D)) u_dut (
        .clk(clk), .rst_n(rst_n), .count_i(count_i), .upd_strobe(upd_strobe),
        .hold_n(hold_n), .hi_en_n(hi_en_n), .lo_en_n(lo_en_n),
        .hi_data(hi_data), .hi_oe(hi_oe), .lo_data(lo_data), .lo_oe(lo_oe)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference, advanced on every rising edge and compared 5 ns later.
    always @(posedge clk) begin
        bit en [2];
        en[1] = hi_en_n;
        en[0] = lo_en_n;
        if (!rst_n) begin
            m_latch = '0; m_hold_q = 1; m_busy_q = 1;
            for (int g = 0; g < 2; g++) begin m_oe[g] = 0; m_run[g] = 0; end
        end else begin
            if (hold_n && (!m_hold_q || (upd_strobe && !m_busy_q))) m_latch = count_i;
            m_hold_q = hold_n;
            m_busy_q = upd_strobe;
            for (int g = 0; g < 2; g++) begin
                if ((!en[g]) != m_oe[g]) begin
                    m_run[g]++;
                    if (m_run[g] == (m_oe[g] ? REL_D : EN_D)) begin
                        m_oe[g] = !m_oe[g];
                        m_run[g] = 0;
                    end
                end else m_run[g] = 0;
            end
        end
        #5;
        if (!done) begin
            chk({phase, " hi_oe"}, hi_oe, m_oe[1]);
            chk({phase, " lo_oe"}, lo_oe, m_oe[0]);
            chk({phase, " hi_data"}, hi_data, m_oe[1] ? m_latch[15:8] : 8'h00);
            chk({phase, " lo_data"}, lo_data, m_oe[0] ? m_latch[7:0] : 8'h00);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe(input logic [15:0] v);
        count_i = v; upd_strobe = 1'b1; tick(1);
        upd_strobe = 1'b0; tick(1);
    endtask

    initial begin
        #(20ns * 100000);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        tick(4);
        chk("R1 hi_oe reset", hi_oe, 0);
        chk("R1 lo_data reset", lo_data, 0);
        rst_n = 1'b1;
        tick(2);
        chk("R1 hi_data after reset", hi_data, 0);

        // R2: copy on leading edge, held-high strobe does not recopy.
        phase = "R2";
        hi_en_n = 0; lo_en_n = 0; tick(EN_D + 1);
        count_i = 16'hA55A; upd_strobe = 1; tick(1);
        chk("R2 hi copy", hi_data, 8'hA5);
        chk("R6 lo byte", lo_data, 8'h5A);
        count_i = 16'h1111; tick(3);
        chk("R2 no recopy while high", {hi_data, lo_data}, 16'hA55A);
        upd_strobe = 0; tick(1);
        strobe(16'hC3E1);
        chk("R6 upper bits", hi_data, 8'hC3);

        // R3/R4: frozen while hold_n is low.
        phase = "R3";
        hold_n = 0; count_i = 16'h7777; tick(1);
        chk("R3 frozen", {hi_data, lo_data}, 16'hC3E1);
        phase = "R4";
        strobe(16'h0F0F); strobe(16'hFFFF);
        chk("R4 strobe ignored", {hi_data, lo_data}, 16'hC3E1);

        // R5: release picks up the live count.
        phase = "R5";
        count_i = 16'h1234; hold_n = 1; tick(1);
        chk("R5 release copy", {hi_data, lo_data}, 16'h1234);

        // R7: short enable pulse on lower group, and exact turn-on.
        phase = "R7";
        lo_en_n = 1; tick(REL_D);
        chk("R8 lo off after delay", lo_oe, 0);
        lo_en_n = 0; tick(EN_D - 1); lo_en_n = 1; tick(2);
        chk("R7 short pulse ignored", lo_oe, 0);
        lo_en_n = 0; tick(EN_D - 1);
        chk("R7 not yet on", lo_oe, 0);
        tick(1);
        chk("R7 on at delay", lo_oe, 1);

        // R8: short release pulse keeps drive on.
        phase = "R8";
        lo_en_n = 1; tick(REL_D - 1); lo_en_n = 0; tick(1);
        chk("R8 short release ignored", lo_oe, 1);

        // R10: lower disabled while upper keeps showing data.
        phase = "R10";
        lo_en_n = 1; tick(REL_D + 1);
        strobe(16'hBEEF);
        chk("R10 hi still driven", hi_data, 8'hBE);
        chk("R9 lo quiet when off", lo_data, 8'h00);

        // R9: mixed stimulus checked by the model every clock.
        phase = "R9";
        for (int i = 0; i < 400; i++) begin
            count_i = count_i * 16'd5 + 16'd7;
            upd_strobe = (i % 3) == 0;
            hold_n = (i % 23) < 17;
            hi_en_n = (i % 11) > 6;
            lo_en_n = (i % 7) > 3;
            tick(1);
        end
        tick(5);
        done = 1'b1;
        tick(1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule